// File: doc/BRIEF.md
# Nibble-Serial Clock Command Port

This block is the command path through which a processor reads and sets a 28-bit clock value four bits at a time. It listens only while the cartridge control value equals 0x0B. In that state every byte written to the data window is a command: bits 7:4 carry the opcode and bits 3:0 carry a data nibble or a sub-command. A nibble pointer selects which four-bit slice of the clock value the next access touches, and a direction flag says whether the port is reading the clock out or assembling a new value.

In read direction, each step command copies one slice of the live clock value into a four-bit result latch and moves the pointer to the next slice, wrapping after the top slice. In write direction, each step command places its data nibble into a staging register. The first nibble of a sequence clears the staging register. The seventh nibble completes the value. It raises a one-cycle load strobe that hands the staged value to the clock counter, returns the pointer to slice 0, and turns the port to read direction. The direction can also be set by explicit commands.

Top module: `nclk_cmd_port`

## Requirements
- R1: After reset the result latch `rd_nibble` holds 0x1, `load_valid` is 0, the pointer is at slice 0 and the port is in write direction.
- R2: A strobed byte is ignored unless `ctrl_val` equals 0x0B: no output and no internal state changes.
- R3: Opcode 0x1 in read direction puts `time_in` bits [4k+3:4k] on `rd_nibble` in the cycle after the command, k being the pointer; the pointer then moves to k+1, and after k=6 it returns to 0.
- R4: Opcode 0x3 in write direction places data bits 3:0 at slice k of the staging value and moves the pointer on; when k is 0 the staging value is first cleared.
- R5: The opcode 0x3 that writes slice 6 makes `load_valid` 1 for exactly the next cycle with `load_value` equal to the full staged value, returns the pointer to 0 and selects read direction.
- R6: Byte 0x40 returns the pointer to slice 0 and leaves the direction unchanged.
- R7: Byte 0x43 selects write direction and byte 0x47 selects read direction; both return the pointer to slice 0.
- R8: Opcode 0x6 selects read direction and leaves the pointer where it is.
- R9: Opcodes 0x0, 0x2, 0x5 and 0x7 to 0xF, and opcode 0x4 with any low nibble other than 0x0, 0x3 or 0x7, change nothing.
- R10: Opcode 0x3 in read direction and opcode 0x1 in write direction change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | One-cycle strobe: a byte is written to the data window |
| cmd_byte | input | 8 | Written byte: opcode in 7:4, data or sub-command in 3:0 |
| ctrl_val | input | 8 | Current cartridge control value; commands act only at 0x0B |
| time_in | input | 28 | Live clock value from the clock counter |
| load_valid | output | 1 | One-cycle strobe: a new clock value is ready |
| load_value | output | 28 | Clock value to load, valid with `load_valid` |
| rd_nibble | output | 4 | Result latch holding the last slice read |

## Verification
On every cycle the checker shows that a byte arriving under any other control value leaves the result latch still and raises no load, that the result latch moves only after a read step, that a load strobe lasts one cycle and always follows a write step, and that undefined opcodes disturb neither output. The pointer position, the direction flag and the clearing of the staging value are not visible at the ports, so only the bench's command sequences show them: reads after direction changes, pointer resets in mid-sequence, the wrap after slice 6 and the value delivered at the end of a rewritten sequence.

// File: rtl/nclk_pkg.sv
package nclk_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        OP_STEP_RD = 4'h1,
        OP_NOP_A   = 4'h2,
        OP_STEP_WR = 4'h3,
        OP_MISC    = 4'h4,
        OP_NOP_B   = 4'h5,
        OP_SEL_RD  = 4'h6
    } nclk_op_e;

    typedef enum logic [3:0] {
        SUB_PTR_CLR = 4'h0,
        SUB_WR_MODE = 4'h3,
        SUB_RD_MODE = 4'h7
    } nclk_sub_e;

    typedef struct packed {
        logic             rd_step;
        logic             wr_step;
        logic             ptr_clr;
        logic             sel_wr;
        logic             sel_rd;
        logic [NIB_W-1:0] data;
    } nclk_dec_t;

    function automatic nclk_dec_t nclk_decode(input logic [7:0] b);
        nclk_dec_t d;
        d = '0;
        d.data = b[3:0];
        case (b[7:4])
            OP_STEP_RD: d.rd_step = 1'b1;
            OP_STEP_WR: d.wr_step = 1'b1;
            OP_SEL_RD:  d.sel_rd  = 1'b1;
            OP_MISC: begin
                case (b[3:0])
                    SUB_PTR_CLR: d.ptr_clr = 1'b1;
                    SUB_WR_MODE: begin d.ptr_clr = 1'b1; d.sel_wr = 1'b1; end
                    SUB_RD_MODE: begin d.ptr_clr = 1'b1; d.sel_rd = 1'b1; end
                    default: ;
                endcase
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/nclk_decoder.sv
module nclk_decoder
    import nclk_pkg::*;
#(
    parameter logic [7:0] CTRL_SEL = 8'h0B
) (
    input  logic      cmd_we,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] ctrl_val,
    output nclk_dec_t dec
);
    logic active;
    assign active = cmd_we && (ctrl_val == CTRL_SEL);

    always_comb begin
        dec = nclk_decode(cmd_byte);
        if (!active) begin
            dec.rd_step = 1'b0;
            dec.wr_step = 1'b0;
            dec.ptr_clr = 1'b0;
            dec.sel_wr  = 1'b0;
            dec.sel_rd  = 1'b0;
        end
    end
endmodule

// File: rtl/nclk_seq.sv
module nclk_seq
    import nclk_pkg::*;
#(
    parameter int NIBBLES = 7,
    localparam int IDX_W  = $clog2(NIBBLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  nclk_dec_t        dec,
    output logic [IDX_W-1:0] idx,
    output logic             fire_rd,
    output logic             fire_wr,
    output logic             last
);
    logic rd_mode;

    assign last    = (idx == IDX_W'(NIBBLES - 1));
    assign fire_rd = dec.rd_step && rd_mode;
    assign fire_wr = dec.wr_step && !rd_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            rd_mode <= 1'b0;
        end else begin
            if (fire_rd) begin
                idx <= last ? '0 : idx + 1'b1;
            end
            if (fire_wr) begin
                if (last) begin
                    idx     <= '0;
                    rd_mode <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (dec.ptr_clr) idx     <= '0;
            if (dec.sel_wr)  rd_mode <= 1'b0;
            if (dec.sel_rd)  rd_mode <= 1'b1;
        end
    end
endmodule

// File: rtl/nclk_stage.sv
module nclk_stage
    import nclk_pkg::*;
#(
    parameter int NIBBLES = 7,
    localparam int IDX_W  = $clog2(NIBBLES),
    localparam int TIME_W = NIBBLES * NIB_W,
    localparam int SH_W   = $clog2(TIME_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_wr,
    input  logic              last,
    input  logic [IDX_W-1:0]  idx,
    input  logic [NIB_W-1:0]  data,
    output logic              load_valid,
    output logic [TIME_W-1:0] load_value
);
    logic [SH_W-1:0]   sh_amt;
    logic [TIME_W-1:0] base;

    assign sh_amt = SH_W'(idx) * SH_W'(NIB_W);
    assign base   = (idx == '0) ? '0 : load_value;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_value <= '0;
            load_valid <= 1'b0;
        end else begin
            load_valid <= fire_wr && last;
            if (fire_wr) begin
                load_value <= base | (TIME_W'(data) << sh_amt);
            end
        end
    end
endmodule

// File: rtl/nclk_rdlatch.sv
module nclk_rdlatch
    import nclk_pkg::*;
#(
    parameter int NIBBLES = 7,
    localparam int IDX_W  = $clog2(NIBBLES),
    localparam int TIME_W = NIBBLES * NIB_W,
    localparam int SH_W   = $clog2(TIME_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_rd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TIME_W-1:0] time_in,
    output logic [NIB_W-1:0]  rd_nibble
);
    logic [SH_W-1:0]   sh_amt;
    logic [TIME_W-1:0] shifted;

    assign sh_amt  = SH_W'(idx) * SH_W'(NIB_W);
    assign shifted = time_in >> sh_amt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_nibble <= NIB_W'(1);
        end else if (fire_rd) begin
            rd_nibble <= shifted[NIB_W-1:0];
        end
    end
endmodule

// File: rtl/nclk_cmd_port.sv
module nclk_cmd_port
    import nclk_pkg::*;
#(
    parameter logic [7:0] CTRL_SEL = 8'h0B,
    parameter int NIBBLES          = 7,
    localparam int IDX_W           = $clog2(NIBBLES),
    localparam int TIME_W          = NIBBLES * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_byte,
    input  logic [7:0]        ctrl_val,
    input  logic [TIME_W-1:0] time_in,
    output logic              load_valid,
    output logic [TIME_W-1:0] load_value,
    output logic [NIB_W-1:0]  rd_nibble
);
    nclk_dec_t        dec;
    logic [IDX_W-1:0] idx;
    logic             fire_rd;
    logic             fire_wr;
    logic             last;

    nclk_decoder #(.CTRL_SEL(CTRL_SEL)) u_dec (
        .cmd_we   (cmd_we),
        .cmd_byte (cmd_byte),
        .ctrl_val (ctrl_val),
        .dec      (dec)
    );

    nclk_seq #(.NIBBLES(NIBBLES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .idx     (idx),
        .fire_rd (fire_rd),
        .fire_wr (fire_wr),
        .last    (last)
    );

    nclk_stage #(.NIBBLES(NIBBLES)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .fire_wr    (fire_wr),
        .last       (last),
        .idx        (idx),
        .data       (dec.data),
        .load_valid (load_valid),
        .load_value (load_value)
    );

    nclk_rdlatch #(.NIBBLES(NIBBLES)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .fire_rd   (fire_rd),
        .idx       (idx),
        .time_in   (time_in),
        .rd_nibble (rd_nibble)
    );
endmodule

// File: rtl/nclk_cmd_port_chk.sv
module nclk_cmd_port_chk #(
    parameter logic [7:0] CTRL_SEL = 8'h0B,
    parameter int TIME_W           = 28
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_we,
    input logic [7:0]        cmd_byte,
    input logic [7:0]        ctrl_val,
    input logic              load_valid,
    input logic [TIME_W-1:0] load_value,
    input logic [3:0]        rd_nibble
);
    logic live;
    logic undef_op;
    assign live     = cmd_we && (ctrl_val == CTRL_SEL);
    assign undef_op = (cmd_byte[7:4] == 4'h0) || (cmd_byte[7:4] == 4'h2) ||
                      (cmd_byte[7:4] == 4'h5) || (cmd_byte[7:4] >= 4'h7);

    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && ctrl_val != CTRL_SEL) |=> ($stable(rd_nibble) && !load_valid));

    p_latch_src_r3: assert property (@(posedge clk) disable iff (rst)
        !(live && cmd_byte[7:4] == 4'h1) |=> $stable(rd_nibble));

    p_load_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        load_valid |=> !load_valid);

    p_load_cause_r5: assert property (@(posedge clk) disable iff (rst)
        !(live && cmd_byte[7:4] == 4'h3) |=> !load_valid);

    p_undef_r9: assert property (@(posedge clk) disable iff (rst)
        (live && undef_op) |=> ($stable(rd_nibble) && !load_valid));

    p_load_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(live && cmd_byte[7:4] == 4'h3) |=> $stable(load_value));
endmodule

bind nclk_cmd_port nclk_cmd_port_chk #(.CTRL_SEL(CTRL_SEL), .TIME_W(TIME_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_we     (cmd_we),
    .cmd_byte   (cmd_byte),
    .ctrl_val   (ctrl_val),
    .load_valid (load_valid),
    .load_value (load_value),
    .rd_nibble  (rd_nibble)
);

// File: tb/nclk_cmd_port_bench.sv
module nclk_cmd_port_bench;
    localparam int TW = 28;

    typedef struct {
        logic [3:0]    rd;
        logic          ld;
        logic [TW-1:0] val;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_we = 1'b0;
    logic [7:0]    cmd_byte = 8'h00;
    logic [7:0]    ctrl_val = 8'h00;
    logic [TW-1:0] time_in = '0;
    logic          load_valid;
    logic [TW-1:0] load_value;
    logic [3:0]    rd_nibble;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    // bench expectation state derived from the requirements
    bit            m_rd = 1'b0;
    int            m_idx = 0;
    logic [TW-1:0] m_stage = '0;
    logic [3:0]    m_out = 4'h1;

    always #4 clk = ~clk;

    nclk_cmd_port u_nclk_cmd_port (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .ctrl_val(ctrl_val), .time_in(time_in), .load_valid(load_valid),
        .load_value(load_value), .rd_nibble(rd_nibble)
    );

    task automatic push(input bit ld, input string tag);
        exp_t e;
        e.rd = m_out; e.ld = ld; e.val = m_stage; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic send(input logic [7:0] ctrl, input logic [7:0] b, input string tag);
        bit ld = 1'b0;
        @(negedge clk);
        ctrl_val = ctrl; cmd_byte = b; cmd_we = 1'b1;
        if (ctrl == 8'h0B) begin
            case (b[7:4])
                4'h1: if (m_rd) begin
                    m_out = 4'((time_in >> (4 * m_idx)) & 28'hF);
                    m_idx = (m_idx == 6) ? 0 : m_idx + 1;
                end
                4'h3: if (!m_rd) begin
                    if (m_idx == 0) m_stage = '0;
                    m_stage = m_stage | (TW'(b[3:0]) << (4 * m_idx));
                    if (m_idx == 6) begin m_idx = 0; m_rd = 1'b1; ld = 1'b1; end
                    else m_idx = m_idx + 1;
                end
                4'h4: case (b[3:0])
                    4'h0: m_idx = 0;
                    4'h3: begin m_idx = 0; m_rd = 1'b0; end
                    4'h7: begin m_idx = 0; m_rd = 1'b1; end
                    default: ;
                endcase
                4'h6: m_rd = 1'b1;
                default: ;
            endcase
        end
        push(ld, tag);
        @(negedge clk);
        cmd_we = 1'b0;
        push(1'b0, tag);
    endtask

    // monitor: compare one queued expectation per cycle, between edges
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rd_nibble !== e.rd || load_valid !== e.ld ||
                    (e.ld && load_value !== e.val)) begin
                    errors++;
                    $display("FAIL %s rd=%h exp %h ld=%b exp %b val=%h exp %h",
                             e.tag, rd_nibble, e.rd, load_valid, e.ld, load_value, e.val);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rd_nibble !== 4'h1 || load_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rd=%h exp 1 ld=%b exp 0", rd_nibble, load_valid);
        end

        // R2: wrong control value, nothing moves
        time_in = 28'h9876543;
        send(8'h0A, 8'h35, "R2");
        send(8'h0C, 8'h47, "R2");
        send(8'h00, 8'h61, "R2");
        send(8'h0B, 8'h10, "R10");  // still write direction: no read

        // R4/R5: full write sequence 1..7
        for (int i = 1; i <= 7; i++) send(8'h0B, 8'h30 | 8'(i), "R5");

        // R3: read all slices and wrap
        time_in = 28'hABCDEF1;
        for (int i = 0; i < 8; i++) send(8'h0B, 8'h10, "R3");

        // R10: write step in read direction ignored
        send(8'h0B, 8'h3F, "R10");
        send(8'h0B, 8'h10, "R10");

        // R6: pointer reset
        send(8'h0B, 8'h40, "R6");
        send(8'h0B, 8'h10, "R6");
        send(8'h0B, 8'h10, "R6");

        // R7: write direction, then rewrite with mid-sequence pointer reset
        send(8'h0B, 8'h43, "R7");
        send(8'h0B, 8'h10, "R7");
        send(8'h0B, 8'h3A, "R4");
        send(8'h0B, 8'h3B, "R4");
        send(8'h0B, 8'h40, "R4");
        for (int i = 0; i < 7; i++) send(8'h0B, 8'h38 - 8'(i), "R4");

        // R7: read select from mid write sequence
        send(8'h0B, 8'h43, "R7");
        send(8'h0B, 8'h32, "R7");
        send(8'h0B, 8'h47, "R7");
        send(8'h0B, 8'h10, "R7");

        // R8: read select keeps pointer
        send(8'h0B, 8'h43, "R8");
        send(8'h0B, 8'h31, "R8");
        send(8'h0B, 8'h32, "R8");
        send(8'h0B, 8'h60, "R8");
        send(8'h0B, 8'h10, "R8");

        // R9: undefined and no-op commands
        send(8'h0B, 8'h00, "R9");
        send(8'h0B, 8'h2F, "R9");
        send(8'h0B, 8'h53, "R9");
        for (int op = 7; op < 16; op++) send(8'h0B, {4'(op), 4'h0}, "R9");
        send(8'h0B, 8'h41, "R9");
        send(8'h0B, 8'h4F, "R9");
        send(8'h0B, 8'h10, "R9");
        send(8'h0B, 8'h10, "R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule